// File: doc/BRIEF.md
# Breadth-First Delay-Line Path Scheduler

This block schedules single-slot bursts through a blocking time-slot interchanger. The interchanger's delay lines have lengths 1, 2, 4 and so on up to half a frame. The scheduler keeps a busy bitmap with one row per delay line and one row for the output link. Each row is indexed by time relative to the present slot. A delay line is busy at time t when some slot leaves that line at t. The output link is busy at t when an outgoing slot at t is already taken.

A request asks for a route for a slot that arrives now. The block runs a breadth-first search over cumulative delays. Each cycle it expands one whole hop level. It picks the free output slot reached with the fewest delay-line hops, and among those the smallest delay. It reports the chosen delay, the hop count and the ordered list of delay lines, then marks every resource it used as busy. If no exit is reachable within the hop limit, the burst is dropped and the schedule is left unchanged.

A time-advance strobe moves the whole bitmap one slot toward the present. A preload port lets the controller mark output slots as taken by other traffic.

Requests and preloads use valid/ready handshakes. Ready is high only while the block is idle, there is no time-advance strobe in the same cycle and no held strobe is waiting. From the accepting edge until the result pulse, the block accepts neither a request nor a preload, so the upstream holds its valid. The result is a one-cycle pulse with no back-pressure.

Top module: `bfs_delay_sched`

## Requirements
- R1: After reset the schedule is entirely free, req_ready and pre_ready are high and res_valid is low. The first request with no preload returns success with delay 0 and 0 hops.
- R2: A request is accepted on an edge where req_valid and req_ready are both high. req_ready then stays low until the result. res_valid is high for exactly one cycle. It rises H+1 edges after the accepting edge, where H is the hop level at which the search ended.
- R3: A cumulative delay d is a valid exit when output-row bit d is 0. The chosen exit has the fewest hops, and among exits with equal hops it has the smallest delay.
- R4: Line h has delay 2^h, where h = 0 is the shortest line. A hop on line h from delay i to delay j = i + 2^h is allowed only when j < SLOTS and the bit for line h at time j is 0. A delay already reached at a lower level is never revisited.
- R5: If no exit is found at a level not greater than HOP_LIMIT, or if no new delay can be reached, the result has res_ok = 0 with delay, hops and line list all zero.
- R6: In res_lines, field s occupies bits [s*LW +: LW]. For s < res_hops it holds the line index of hop s, where hop 0 is the first hop taken from time 0. Fields at or above res_hops are zero, and the hop delays add up to res_delay. When several predecessors at one level reach the same delay, the one with the smallest delay is kept, so that delay is reached on the longest usable line.
- R7: On success the output bit at the chosen delay is set busy. For each hop, the bit of its line at that hop's exit time (the cumulative delay after the hop) is also set busy. A drop changes no bit.
- R8: A slot_tick accepted while idle shifts every row one column toward time 0, and the far column becomes free. A slot_tick during a search is held and applied on the first idle cycle, and it blocks acceptance in that cycle.
- R9: A preload is accepted when pre_valid and pre_ready are both high, and it marks output slot pre_slot busy. pre_ready equals req_ready. A preload accepted on the same edge as a request is seen by that request's search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Route request for the slot arriving now |
| req_ready | output | 1 | Request can be accepted this cycle |
| slot_tick | input | 1 | Time advances by one slot |
| pre_valid | input | 1 | Output-slot preload valid |
| pre_ready | output | 1 | Preload can be accepted this cycle |
| pre_slot | input | SW | Output slot to mark busy |
| res_valid | output | 1 | Result pulse |
| res_ok | output | 1 | 1 = route found, 0 = burst dropped |
| res_delay | output | SW | Chosen cumulative delay in slots |
| res_hops | output | HW | Number of delay lines used |
| res_lines | output | HOP_LIMIT*LW | Ordered delay-line indices, LW bits per hop |

## Verification
The bench builds the block with SLOTS = 8 and HOP_LIMIT = 2. That gives three lines of 1, 2 and 4 slots, and delay 7 needs three hops. So the hop-limit drop is reached after only a few requests. With only eight columns, the schedule fills up within a handful of back-to-back requests, so full-frame drops and frontier exhaustion are exercised. It also means ticks often move committed busy bits across time 0 within a short run. The random phase mixes requests, ticks held during searches and preloads on the same edge as requests.

// File: rtl/bfs_sched_pkg.sv
package bfs_sched_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SRCH = 1'b1
  } sched_state_t;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bfs_sched_store.sv
module bfs_sched_store #(
  parameter int SLOTS = 16,
  parameter int LINES = 4,
  parameter int SW    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        shift_en,
  input  logic                        pre_en,
  input  logic [SW-1:0]               pre_slot,
  input  logic                        commit_en,
  input  logic [LINES:0][SLOTS-1:0]   commit_mask,
  output logic [LINES:0][SLOTS-1:0]   sched
);

  logic [LINES:0][SLOTS-1:0] sched_d;

  // Row 0 is the output link; row h+1 is the line of delay 2^h.
  always_comb begin
    for (int r = 0; r <= LINES; r++) begin
      if (shift_en) begin
        sched_d[r] = {1'b0, sched[r][SLOTS-1:1]};
      end else if (commit_en) begin
        sched_d[r] = sched[r] | commit_mask[r];
      end else begin
        sched_d[r] = sched[r];
      end
    end
    if (!shift_en && pre_en) begin
      sched_d[0][pre_slot] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sched <= '0;
    end else begin
      sched <= sched_d;
    end
  end

endmodule

// File: rtl/bfs_level.sv
module bfs_level #(
  parameter int SLOTS = 16,
  parameter int LINES = 4,
  parameter int LW    = 2,
  parameter int SW    = 4
) (
  input  logic [SLOTS-1:0]            frontier,
  input  logic [SLOTS-1:0]            visited,
  input  logic [LINES:0][SLOTS-1:0]   sched,
  output logic [SLOTS-1:0]            next_front,
  output logic [SLOTS-1:0][LW-1:0]    via_n,
  output logic                        cand_any,
  output logic [SW-1:0]               cand_idx
);

  logic [LINES-1:0][SLOTS-1:0] step;
  logic [SLOTS-1:0]            reach;
  logic [SLOTS-1:0]            cand;

  // One shifted copy of the frontier per line, masked by that line's exits.
  generate
    for (genvar h = 0; h < LINES; h++) begin : g_line
      assign step[h] = (frontier << (1 << h)) & ~sched[h+1];
    end
  endgenerate

  always_comb begin
    reach = '0;
    via_n = '0;
    for (int j = 0; j < SLOTS; j++) begin
      // ascending h: the longest usable line (smallest predecessor) wins
      for (int h = 0; h < LINES; h++) begin
        if (step[h][j]) begin
          reach[j] = 1'b1;
          via_n[j] = LW'(h);
        end
      end
    end
  end

  assign next_front = reach & ~visited;
  assign cand       = frontier & ~sched[0];
  assign cand_any   = |cand;

  always_comb begin
    cand_idx = '0;
    for (int j = SLOTS - 1; j >= 0; j--) begin
      if (cand[j]) begin
        cand_idx = SW'(j);
      end
    end
  end

endmodule

// File: rtl/bfs_path_walk.sv
module bfs_path_walk #(
  parameter int SLOTS     = 16,
  parameter int LINES     = 4,
  parameter int LW        = 2,
  parameter int SW        = 4,
  parameter int HOP_LIMIT = 3,
  parameter int HW        = 2
) (
  input  logic [SW-1:0]               best,
  input  logic [HW-1:0]               hops,
  input  logic [SLOTS-1:0][LW-1:0]    via,
  output logic [HOP_LIMIT*LW-1:0]     lines_flat,
  output logic [LINES:0][SLOTS-1:0]   mask
);

  int node;
  int h;

  // Walk back from the exit; the last hop is recovered first.
  always_comb begin
    lines_flat = '0;
    mask       = '0;
    node       = int'(best);
    h          = 0;
    mask[0][best] = 1'b1;
    for (int s = HOP_LIMIT - 1; s >= 0; s--) begin
      if (s < int'(hops)) begin
        h = int'(via[node]);
        lines_flat[s*LW +: LW] = LW'(h);
        mask[h+1][node] = 1'b1;
        node = node - (1 << h);
      end
    end
  end

endmodule

// File: rtl/bfs_delay_sched.sv
module bfs_delay_sched
  import bfs_sched_pkg::*;
#(
  parameter  int SLOTS     = 16,
  parameter  int HOP_LIMIT = 3,
  localparam int LINES     = $clog2(SLOTS),
  localparam int LW        = idx_width(LINES),
  localparam int SW        = $clog2(SLOTS),
  localparam int HW        = $clog2(HOP_LIMIT + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    slot_tick,
  input  logic                    pre_valid,
  output logic                    pre_ready,
  input  logic [SW-1:0]           pre_slot,
  output logic                    res_valid,
  output logic                    res_ok,
  output logic [SW-1:0]           res_delay,
  output logic [HW-1:0]           res_hops,
  output logic [HOP_LIMIT*LW-1:0] res_lines
);

  localparam logic [HW-1:0] LIM = HW'(HOP_LIMIT);

  sched_state_t                state_q;
  logic [SLOTS-1:0]            front_q;
  logic [SLOTS-1:0]            vis_q;
  logic [SLOTS-1:0][LW-1:0]    via_q;
  logic [HW-1:0]               level_q;
  logic                        pend_q;

  logic [LINES:0][SLOTS-1:0]   sched;
  logic [SLOTS-1:0]            next_front;
  logic [SLOTS-1:0][LW-1:0]    via_n;
  logic                        cand_any;
  logic [SW-1:0]               cand_idx;
  logic [HOP_LIMIT*LW-1:0]     walk_lines;
  logic [LINES:0][SLOTS-1:0]   walk_mask;

  logic idle, srch, accept, shift_en, pre_en, found, give_up;

  assign idle      = (state_q == ST_IDLE);
  assign srch      = (state_q == ST_SRCH);
  assign req_ready = idle && !slot_tick && !pend_q;
  assign pre_ready = req_ready;
  assign accept    = req_valid && req_ready;
  assign pre_en    = pre_valid && pre_ready;
  assign shift_en  = idle && (slot_tick || pend_q);
  assign found     = srch && cand_any;
  assign give_up   = srch && !cand_any && ((level_q == LIM) || (next_front == '0));

  bfs_sched_store #(.SLOTS(SLOTS), .LINES(LINES), .SW(SW)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .shift_en    (shift_en),
    .pre_en      (pre_en),
    .pre_slot    (pre_slot),
    .commit_en   (found),
    .commit_mask (walk_mask),
    .sched       (sched)
  );

  bfs_level #(.SLOTS(SLOTS), .LINES(LINES), .LW(LW), .SW(SW)) u_level (
    .frontier   (front_q),
    .visited    (vis_q),
    .sched      (sched),
    .next_front (next_front),
    .via_n      (via_n),
    .cand_any   (cand_any),
    .cand_idx   (cand_idx)
  );

  bfs_path_walk #(
    .SLOTS(SLOTS), .LINES(LINES), .LW(LW), .SW(SW),
    .HOP_LIMIT(HOP_LIMIT), .HW(HW)
  ) u_walk (
    .best       (cand_idx),
    .hops       (level_q),
    .via        (via_q),
    .lines_flat (walk_lines),
    .mask       (walk_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      front_q   <= '0;
      vis_q     <= '0;
      via_q     <= '0;
      level_q   <= '0;
      pend_q    <= 1'b0;
      res_valid <= 1'b0;
      res_ok    <= 1'b0;
      res_delay <= '0;
      res_hops  <= '0;
      res_lines <= '0;
    end else begin
      res_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          pend_q <= 1'b0;
          if (accept) begin
            state_q <= ST_SRCH;
            front_q <= SLOTS'(1);
            vis_q   <= SLOTS'(1);
            via_q   <= '0;
            level_q <= '0;
          end
        end
        ST_SRCH: begin
          pend_q <= pend_q | slot_tick;
          if (found) begin
            res_valid <= 1'b1;
            res_ok    <= 1'b1;
            res_delay <= cand_idx;
            res_hops  <= level_q;
            res_lines <= walk_lines;
            state_q   <= ST_IDLE;
          end else if (give_up) begin
            res_valid <= 1'b1;
            res_ok    <= 1'b0;
            res_delay <= '0;
            res_hops  <= '0;
            res_lines <= '0;
            state_q   <= ST_IDLE;
          end else begin
            front_q <= next_front;
            vis_q   <= vis_q | next_front;
            level_q <= level_q + 1'b1;
            for (int j = 0; j < SLOTS; j++) begin
              if (next_front[j]) begin
                via_q[j] <= via_n[j];
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bfs_delay_sched_chk.sv
module bfs_delay_sched_chk #(
  parameter int SLOTS     = 16,
  parameter int HOP_LIMIT = 3,
  parameter int LW        = 2,
  parameter int SW        = 4,
  parameter int HW        = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    res_valid,
  input logic                    res_ok,
  input logic [SW-1:0]           res_delay,
  input logic [HW-1:0]           res_hops,
  input logic [HOP_LIMIT*LW-1:0] res_lines
);

  int   path_sum;
  logic pad_ok;

  always_comb begin
    path_sum = 0;
    pad_ok   = 1'b1;
    for (int s = 0; s < HOP_LIMIT; s++) begin
      if (s < int'(res_hops)) begin
        path_sum = path_sum + (1 << int'(res_lines[s*LW +: LW]));
      end else if (res_lines[s*LW +: LW] != '0) begin
        pad_ok = 1'b0;
      end
    end
  end

  AST_ACCEPT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2

  AST_NO_EARLY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !res_valid); // R2

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R2

  AST_HOP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ok) |-> (int'(res_hops) <= HOP_LIMIT)); // R5

  AST_DROP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ok) |-> (res_delay == '0 && res_hops == '0 && res_lines == '0)); // R5

  AST_PATH_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ok) |-> (path_sum == int'(res_delay) && pad_ok)); // R6

endmodule

bind bfs_delay_sched bfs_delay_sched_chk #(
  .SLOTS(SLOTS), .HOP_LIMIT(HOP_LIMIT), .LW(LW), .SW(SW), .HW(HW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .res_valid (res_valid),
  .res_ok    (res_ok),
  .res_delay (res_delay),
  .res_hops  (res_hops),
  .res_lines (res_lines)
);

// File: tb/test_bfs_delay_sched.sv
`timescale 1ns/1ps
module test_bfs_delay_sched;

  localparam int SLOTS = 8;
  localparam int HOP_LIMIT = 2;
  localparam int LINES = 3;
  localparam int LW = 2;
  localparam int SW = 3;
  localparam int HW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic slot_tick = 1'b0;
  logic pre_valid = 1'b0;
  logic [SW-1:0] pre_slot = '0;
  logic req_ready, pre_ready, res_valid, res_ok;
  logic [SW-1:0] res_delay;
  logic [HW-1:0] res_hops;
  logic [HOP_LIMIT*LW-1:0] res_lines;

  int errors = 0;
  int checks = 0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  bfs_delay_sched #(.SLOTS(SLOTS), .HOP_LIMIT(HOP_LIMIT)) i_bfs_delay_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .slot_tick(slot_tick), .pre_valid(pre_valid), .pre_ready(pre_ready),
    .pre_slot(pre_slot), .res_valid(res_valid), .res_ok(res_ok),
    .res_delay(res_delay), .res_hops(res_hops), .res_lines(res_lines)
  );

  // ---------------- reference model ----------------
  bit ms [LINES+1][SLOTS];
  bit m_busy, m_pend, m_resv;
  int m_cnt;
  int p_ok, p_delay, p_hops, p_lvl;
  int p_lines [HOP_LIMIT];
  int e_ok, e_delay, e_hops;
  int e_lines [HOP_LIMIT];

  task automatic model_search();
    bit f [SLOTS];
    bit vis [SLOTS];
    bit nx [SLOTS];
    int via [SLOTS];
    int best, node, any;
    foreach (f[j]) begin f[j] = 0; vis[j] = 0; via[j] = 0; end
    f[0] = 1; vis[0] = 1;
    p_ok = 0; p_delay = 0; p_hops = 0;
    foreach (p_lines[s]) p_lines[s] = 0;
    for (int lvl = 0; lvl <= HOP_LIMIT; lvl++) begin
      best = -1;
      for (int d = SLOTS - 1; d >= 0; d--) if (f[d] && !ms[0][d]) best = d;
      p_lvl = lvl;
      if (best >= 0) begin
        p_ok = 1; p_delay = best; p_hops = lvl; node = best;
        for (int s = lvl - 1; s >= 0; s--) begin
          p_lines[s] = via[node];
          node -= (1 << via[node]);
        end
        return;
      end
      any = 0;
      for (int j = 0; j < SLOTS; j++) begin
        nx[j] = 0;
        for (int h = 0; h < LINES; h++)
          if (j >= (1 << h) && !vis[j] && f[j - (1 << h)] && !ms[h+1][j]) begin
            nx[j] = 1; via[j] = h;
          end
        if (nx[j]) any = 1;
      end
      if (!any) return;
      for (int j = 0; j < SLOTS; j++) begin f[j] = nx[j]; if (nx[j]) vis[j] = 1; end
    end
  endtask

  task automatic model_step();
    int t;
    m_resv = 0;
    if (m_busy) begin
      if (slot_tick) m_pend = 1;
      m_cnt--;
      if (m_cnt == 0) begin
        m_busy = 0; m_resv = 1;
        e_ok = p_ok; e_delay = p_delay; e_hops = p_hops;
        foreach (e_lines[s]) e_lines[s] = p_lines[s];
        if (p_ok != 0) begin
          ms[0][p_delay] = 1;
          t = 0;
          for (int s = 0; s < p_hops; s++) begin
            t += (1 << p_lines[s]);
            ms[p_lines[s] + 1][t] = 1;
          end
        end
      end
    end else if (slot_tick || m_pend) begin
      m_pend = 0;
      for (int r = 0; r <= LINES; r++) begin
        for (int c = 0; c < SLOTS - 1; c++) ms[r][c] = ms[r][c+1];
        ms[r][SLOTS-1] = 0;
      end
    end else begin
      if (pre_valid) ms[0][pre_slot] = 1;
      if (req_valid) begin
        model_search();
        m_busy = 1;
        m_cnt = p_lvl + 1;
      end
    end
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (ms[r, c]) ms[r][c] = 0;
      m_busy = 0; m_pend = 0; m_resv = 0; m_cnt = 0;
    end else begin
      model_step();
      #2;
      chk(cur_tag, "req_ready", int'(req_ready), int'(!m_busy && !slot_tick && !m_pend));
      chk(cur_tag, "pre_ready", int'(pre_ready), int'(!m_busy && !slot_tick && !m_pend));
      chk(cur_tag, "res_valid", int'(res_valid), int'(m_resv));
      if (res_valid && m_resv) begin
        chk(cur_tag, "res_ok", int'(res_ok), e_ok);
        chk(cur_tag, "res_delay", int'(res_delay), e_delay);
        chk(cur_tag, "res_hops", int'(res_hops), e_hops);
        for (int s = 0; s < HOP_LIMIT; s++)
          chk(cur_tag, "res_lines field", int'(res_lines[s*LW +: LW]),
              (s < e_hops) ? e_lines[s] : 0);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input bit rq, input bit tk, input bit pv, input int sl);
    @(negedge clk);
    req_valid = rq; slot_tick = tk; pre_valid = pv; pre_slot = SW'(sl);
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0);
  endtask

  task automatic one_req();
    drive(1, 0, 0, 0);
    idle_n(5);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "req_ready after reset", int'(req_ready), 1);
    chk("R1", "res_valid after reset", int'(res_valid), 0);
    cur_tag = "R1";
    one_req();                                  // delay 0, 0 hops
    cur_tag = "R3";
    drive(0, 0, 1, 1); drive(0, 0, 1, 2); idle_n(1);
    one_req(); one_req();                       // exits at 4, then 3
    cur_tag = "R4";
    for (int i = 0; i < 3; i++) one_req();
    cur_tag = "R5";
    for (int i = 0; i < 4; i++) one_req();      // frame full / limit drops
    cur_tag = "R8";
    drive(0, 1, 0, 0); drive(0, 1, 0, 0); idle_n(1);
    drive(1, 0, 0, 0); drive(0, 1, 0, 0); idle_n(5);
    cur_tag = "R7";
    for (int i = 0; i < 4; i++) one_req();
    cur_tag = "R9";
    drive(0, 1, 0, 0); drive(0, 1, 0, 0); drive(0, 1, 0, 0);
    drive(1, 0, 1, 0); idle_n(5);
    drive(1, 0, 1, 1); idle_n(5);
    cur_tag = "R6";
    for (int i = 0; i < 4; i++) begin drive(0, 1, 0, 0); one_req(); end
    cur_tag = "R2";
    for (int i = 0; i < 4000; i++) begin
      drive(($urandom % 3) == 0, ($urandom % 5) == 0,
            ($urandom % 4) == 0, int'($urandom % SLOTS));
    end
    idle_n(6);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

endmodule